// File: doc/BRIEF.md
# Double-Edge Six-Bit PWM Modulator

This block turns two streams of 6-bit signed codes into two-level pulse-width outputs for one audio channel. An external strobe marks every sample slot at sixteen times the audio rate. Inside each slot a counter ramps through 64 steps on a fast clock near 1024 times the audio rate. Slots alternate between an up ramp and a down ramp, so together they form a triangle. A code latched at the start of a down ramp places the rising edge of a pulse. The code latched at the start of the following up ramp places its falling edge. Each pulse is centred on the valley of the triangle, and the output period is two slots, or eight times the audio rate.

There are three lanes. The main lane carries the coarse word. The other two carry the fine word and its negation, which gives a pair of outputs shifted in phase. The main lane is limited to about 70% duty, and a flag marks any slot whose coarse code was cut back. Near the peak of each up ramp the main output is guaranteed low. In that gap the block raises a strobe that restarts a free-running fast oscillator, so no phase-locked loop is needed.

Top module: `double_edge_pwm`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, all five outputs are low.
- R2: A code is taken as 6-bit two's complement and mapped to a level v = code + 32 (0..63). The first strobe after reset starts an up ramp, and strobes then alternate up and down ramps. On an up ramp, a lane with level v is high for exactly the first v fast cycles after the strobe, counted from the first rising clock edge after the strobe. With v = 0 the lane stays low.
- R3: On a down ramp, a lane with level v is high for exactly the last v of the 64 cycles. A down ramp followed by an up ramp therefore gives one contiguous pulse across the valley, v_down + v_up cycles long.
- R4: Codes are sampled only in the cycle a strobe is present. A change in a code between strobes has no effect on any output during the current ramp.
- R5: The negated fine lane uses the level of minus the fine code. Negating -32 saturates to +31, which gives level 63. For every other fine code, the two fine lanes spend 64 high cycles in total per ramp.
- R6: A main level above DUTY_LIM (default 44, meaning codes above +12) is replaced by DUTY_LIM. The clip flag is high for the whole ramp that follows such a strobe and low for every other ramp.
- R7: The oscillator restart output is high for the last RST_CNT cycles (default 8) of every up ramp. It is never high on a down ramp, and never in a cycle where the main output is high.
- R8: If no strobe arrives after 64 cycles, the counter holds at its end value. After an up ramp all lanes stay low and the restart output stays high. After a down ramp, any lane with a non-zero level stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe at the start of each sample slot |
| msb_code | input | 6 | Coarse sample, two's complement |
| lsb_code | input | 6 | Fine sample, two's complement |
| pwm_main_o | output | 1 | PWM output of the coarse word |
| pwm_fine_p_o | output | 1 | PWM output of the fine word |
| pwm_fine_n_o | output | 1 | PWM output of the negated fine word |
| osc_rst_o | output | 1 | Restart strobe for the fast oscillator |
| clip_o | output | 1 | Main code was clipped in the current slot |

## Verification
The properties do not constrain strobe spacing. They rely only on the strobe being sampled on the fast clock, and on RST_CNT not exceeding 64 minus DUTY_LIM, which keeps the restart window inside the region where the main output is low. Exact edge positions hold only when strobes come every 64 cycles. The stimulus therefore issues one-cycle strobes exactly 64 cycles apart, except in the deliberate hold scenario, which stretches a gap to test the saturated counter. Codes are changed only on the falling clock edge. The mid-ramp change in the R4 scenario also lands on a falling edge, away from the strobe cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned LANES   = 3;
  localparam int unsigned L_MAIN  = 0;
  localparam int unsigned L_FINEP = 1;
  localparam int unsigned L_FINEN = 2;

  typedef enum logic {
    RAMP_DOWN = 1'b0,
    RAMP_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/dpwm_tri_counter.sv
module dpwm_tri_counter
  import dpwm_pkg::*;
#(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned RST_CNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             turn_i,
  output logic [CNT_W-1:0] cnt_o,
  output ramp_dir_e        dir_o,
  output logic             osc_rst_o
);
  localparam logic [CNT_W-1:0] TOP      = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] RST_FROM = TOP - CNT_W'(RST_CNT) + ONE;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ramp_dir_e        dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (turn_i) begin
      dir_d = (dir_q == RAMP_UP) ? RAMP_DOWN : RAMP_UP;
      cnt_d = (dir_q == RAMP_UP) ? TOP : '0;
    end else if (dir_q == RAMP_UP && cnt_q != TOP) begin
      cnt_d = cnt_q + ONE;
    end else if (dir_q == RAMP_DOWN && cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= RAMP_DOWN;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign dir_o     = dir_q;
  assign osc_rst_o = (dir_q == RAMP_UP) && (cnt_q >= RST_FROM);

  // R2
  ramp_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!turn_i && dir_q == RAMP_UP && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + ONE));

  // R3
  ramp_step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!turn_i && dir_q == RAMP_DOWN && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R2
  turn_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_i |=> (dir_q != $past(dir_q)));

  // R8
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!turn_i && ((dir_q == RAMP_UP && cnt_q == TOP) || (dir_q == RAMP_DOWN && cnt_q == '0)))
    |=> $stable(cnt_q));
endmodule

// File: rtl/dpwm_code_map.sv
module dpwm_code_map #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned DUTY_LIM = 44
) (
  input  logic [CODE_W-1:0] msb_i,
  input  logic [CODE_W-1:0] lsb_i,
  output logic [CODE_W-1:0] main_o,
  output logic [CODE_W-1:0] fine_p_o,
  output logic [CODE_W-1:0] fine_n_o,
  output logic              clip_o
);
  localparam logic [CODE_W-1:0] LIM = CODE_W'(DUTY_LIM);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic [CODE_W-1:0] main_off, fine_off;

  always_comb begin
    // offset binary: invert the sign bit
    main_off = {~msb_i[CODE_W-1], msb_i[CODE_W-2:0]};
    fine_off = {~lsb_i[CODE_W-1], lsb_i[CODE_W-2:0]};
    clip_o   = (main_off > LIM);
    main_o   = clip_o ? LIM : main_off;
    fine_p_o = fine_off;
    // level of the negated code is 2^W - level, saturating at the top
    fine_n_o = (fine_off == '0) ? TOP : (~fine_off + 1'b1);
  end
endmodule

// File: rtl/dpwm_cmp_lane.sv
module dpwm_cmp_lane #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] val_o
);
  logic [CNT_W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (ld_i) val_d = val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign pwm_o = (cnt_i < val_q);
  assign val_o = val_q;

  // R4
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(val_q));
endmodule

// File: rtl/double_edge_pwm.sv
module double_edge_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned DUTY_LIM = 44,
  parameter int unsigned RST_CNT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [CODE_W-1:0] msb_code,
  input  logic [CODE_W-1:0] lsb_code,
  output logic              pwm_main_o,
  output logic              pwm_fine_p_o,
  output logic              pwm_fine_n_o,
  output logic              osc_rst_o,
  output logic              clip_o
);
  localparam logic [CODE_W-1:0] LIM = CODE_W'(DUTY_LIM);

  logic [1:0]        sync_q;
  logic              rst_s;
  logic [CODE_W-1:0] cnt;
  ramp_dir_e         dir;
  logic [CODE_W-1:0] lvl   [LANES];
  logic [CODE_W-1:0] held  [LANES];
  logic [LANES-1:0]  pwm;
  logic              clip_d, clip_q, clip_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  dpwm_tri_counter #(.CNT_W(CODE_W), .RST_CNT(RST_CNT)) tri_i (
    .clk       (clk),
    .rst_n     (rst_s),
    .turn_i    (smp_stb),
    .cnt_o     (cnt),
    .dir_o     (dir),
    .osc_rst_o (osc_rst_o)
  );

  dpwm_code_map #(.CODE_W(CODE_W), .DUTY_LIM(DUTY_LIM)) map_i (
    .msb_i    (msb_code),
    .lsb_i    (lsb_code),
    .main_o   (lvl[L_MAIN]),
    .fine_p_o (lvl[L_FINEP]),
    .fine_n_o (lvl[L_FINEN]),
    .clip_o   (clip_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpwm_cmp_lane #(.CNT_W(CODE_W)) lane_i (
      .clk   (clk),
      .rst_n (rst_s),
      .ld_i  (smp_stb),
      .val_i (lvl[g]),
      .cnt_i (cnt),
      .pwm_o (pwm[g]),
      .val_o (held[g])
    );
  end

  always_comb begin
    clip_nx = clip_q;
    if (smp_stb) clip_nx = clip_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) clip_q <= 1'b0;
    else        clip_q <= clip_nx;
  end

  assign pwm_main_o   = pwm[L_MAIN];
  assign pwm_fine_p_o = pwm[L_FINEP];
  assign pwm_fine_n_o = pwm[L_FINEN];
  assign clip_o       = clip_q;

  // R7
  osc_gap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    osc_rst_o |-> !pwm_main_o);

  // R7
  osc_up_only_chk: assert property (@(posedge clk) disable iff (!rst_s)
    osc_rst_o |-> (dir == RAMP_UP));

  // R6
  main_limit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cnt >= LIM) |-> !pwm_main_o);

  // R6
  clip_level_chk: assert property (@(posedge clk) disable iff (!rst_s)
    clip_q |-> (held[L_MAIN] == LIM));

  // R5
  fine_pair_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (held[L_FINEP] != '0) |-> ((held[L_FINEP] + held[L_FINEN]) == '0));
endmodule

// File: tb/double_edge_pwm_tb_top.sv
module double_edge_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_stb;
  logic [5:0] msb_code, lsb_code;
  logic       pwm_main_o, pwm_fine_p_o, pwm_fine_n_o, osc_rst_o, clip_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  up_next = 1'b1;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  double_edge_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .msb_code(msb_code), .lsb_code(lsb_code),
    .pwm_main_o(pwm_main_o), .pwm_fine_p_o(pwm_fine_p_o),
    .pwm_fine_n_o(pwm_fine_n_o), .osc_rst_o(osc_rst_o), .clip_o(clip_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input logic [5:0] c);
    return int'($signed(c)) + 32;
  endfunction

  function automatic int lvl_neg(input logic [5:0] c);
    int s = int'($signed(c));
    return (s == -32) ? 63 : 32 - s;
  endfunction

  // R1
  task automatic t_reset();
    rst_n = 1'b0; smp_stb = 1'b0; msb_code = '0; lsb_code = '0;
    repeat (3) @(negedge clk);
    check("R1 main", pwm_main_o, 0);
    check("R1 osc", osc_rst_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 main", pwm_main_o, 0);
    check("R1 finep", pwm_fine_p_o, 0);
    check("R1 finen", pwm_fine_n_o, 0);
    check("R1 osc", osc_rst_o, 0);
    check("R1 clip", clip_o, 0);
  endtask

  // one 64-cycle ramp; alt changes the codes mid-ramp (R4)
  task automatic ramp(input logic [5:0] m, input logic [5:0] l, input bit alt);
    int hi[3], fst[3], lst[3], ev[3];
    int osc_n = 0, osc_f = -1, clip_n = 0;
    bit up = up_next;
    logic [2:0] o;
    up_next = ~up_next;
    msb_code = m; lsb_code = l; smp_stb = 1'b1;
    for (int j = 0; j < 3; j++) begin hi[j] = 0; fst[j] = -1; lst[j] = -1; end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      smp_stb = 1'b0;
      if (alt && k == 20) begin msb_code = ~m; lsb_code = ~l; end
      o = {pwm_fine_n_o, pwm_fine_p_o, pwm_main_o};
      for (int j = 0; j < 3; j++) if (o[j]) begin
        hi[j]++; if (fst[j] < 0) fst[j] = k; lst[j] = k;
      end
      if (osc_rst_o) begin osc_n++; if (osc_f < 0) osc_f = k; end
      if (clip_o) clip_n++;
    end
    ev[0] = (lvl_of(m) > 44) ? 44 : lvl_of(m);
    ev[1] = lvl_of(l);
    ev[2] = lvl_neg(l);
    for (int j = 0; j < 3; j++) begin
      string tg;
      tg = alt ? "R4" : (j == 0) ? "R6 main" : (j == 2) ? "R5 finen" : (up ? "R2 finep" : "R3 finep");
      check(tg, hi[j], ev[j]);
      check(up ? "R2 first" : "R3 first", fst[j], ev[j] == 0 ? -1 : (up ? 0 : 64 - ev[j]));
      check(up ? "R2 last" : "R3 last", lst[j], ev[j] == 0 ? -1 : (up ? ev[j] - 1 : 63));
    end
    check("R5 pair", hi[1] + hi[2], (lvl_of(l) == 0) ? 63 : 64);
    check("R7 osc count", osc_n, up ? 8 : 0);
    check("R7 osc start", osc_f, up ? 56 : -1);
    check("R6 clip", clip_n, (lvl_of(m) > 44) ? 64 : 0);
  endtask

  task automatic t_sweep(input int mul);
    for (int c = -32; c < 32; c++) ramp(6'(c), 6'(c * mul), 1'b0);
  endtask

  // R4
  task automatic t_midchange();
    ramp(6'd5, 6'd50, 1'b1);
    ramp(6'd60, 6'd7, 1'b1);
  endtask

  // R8
  task automatic t_hold();
    int m_hi, fp_hi, fn_hi, osc_n;
    if (!up_next) ramp(6'd0, 6'd0, 1'b0);
    ramp(6'd3, 6'd9, 1'b0);
    m_hi = 0; fp_hi = 0; fn_hi = 0; osc_n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      m_hi += pwm_main_o; fp_hi += pwm_fine_p_o; fn_hi += pwm_fine_n_o; osc_n += osc_rst_o;
    end
    check("R8 up hold main", m_hi, 0);
    check("R8 up hold finep", fp_hi, 0);
    check("R8 up hold finen", fn_hi, 0);
    check("R8 up hold osc", osc_n, 20);
    ramp(6'd0, 6'h20, 1'b0);
    m_hi = 0; fp_hi = 0; fn_hi = 0; osc_n = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      m_hi += pwm_main_o; fp_hi += pwm_fine_p_o; fn_hi += pwm_fine_n_o; osc_n += osc_rst_o;
    end
    check("R8 down hold main", m_hi, 15);
    check("R8 down hold finep", fp_hi, 0);
    check("R8 down hold finen", fn_hi, 15);
    check("R8 down hold osc", osc_n, 0);
  endtask

  initial begin
    t_reset();
    t_sweep(1);
    ramp(6'd0, 6'd0, 1'b0);
    t_sweep(5);
    t_midchange();
    t_hold();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule